// File: doc/BRIEF.md
# I2C Target Front End with Byte-Boundary Clock Stretching

This block is an I2C target that runs on a fast local clock. It treats the bus clock and data lines as ordinary sampled inputs. Each line passes through a two-stage synchronizer and then a spike filter. A line change is accepted only after it has held for a set number of local clock samples. START and STOP conditions are found on the filtered lines. A 7-bit address with a direction bit is matched, and data bytes are shifted in or out one bit per bus clock.

At every byte boundary that needs local work, the target holds SCL low. A received data byte waits on the receive handshake. A byte to be sent waits on the transmit handshake, both after a read address and after each byte the controller acknowledges. The hold lasts as long as the local logic takes, and there is no timeout. Both bus lines are open-drain: the block only outputs a pull-low enable for each line, and the pad adds the wired-AND and the pull-up.

Local logic reads `rx_data` when `rx_valid` is high and answers with `rx_ready`. It supplies `tx_data` with `tx_valid` while `tx_ready` is high. `addr_hit` pulses for one clock when the address matches.

Top module: `i2c_target_stretch`

## Requirements
- R1: Each bus line is taken through a 2-flop synchronizer and then a filter. The filtered level changes only after FILT_LEN (default 6) consecutive synchronized samples all differ from it. A pulse shorter than that on either line has no effect.
- R2: SDA falling while filtered SCL is high is a START. It begins address reception from any state, including in the middle of a transfer. SDA rising while SCL is high is a STOP. It returns the target to idle with both pull-low enables off.
- R3: The address byte is 7 address bits, MSB first, followed by a direction bit (1 = controller reads). On a match with DEV_ADDR, the target pulls SDA low through the ninth clock and pulses `addr_hit` for one cycle. On a mismatch, it leaves SDA released and ignores the bus until the next START.
- R4: Received bits are sampled on the rising edge of filtered SCL, MSB first. After the eighth falling edge of a data byte, the target presents `rx_valid` with the byte and pulls SDA low for ACK. It holds SCL low until `rx_ready`, then releases SCL and keeps the ACK until the ninth falling edge.
- R5: After a read-address ACK, and after each controller ACK of a sent byte, the target holds SCL low with `tx_ready` high until `tx_valid`. It then loads `tx_data` and drives it MSB first, changing SDA after each falling edge.
- R6: SDA high at the ninth rising edge after a sent byte is a NACK. The target then releases SDA, takes no further transmit bytes and raises no `tx_ready` until the next START.
- R7: The SCL pull-low is raised only while filtered SCL is already low. The SDA pull-low changes only while filtered SCL is low.
- R8: A stretch has no time limit. While `rx_valid` waits for `rx_ready`, or `tx_ready` waits for `tx_valid`, SCL stays held and the presented byte stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL pad level |
| sda_i | input | 1 | Sampled SDA pad level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_hit | output | 1 | One-cycle pulse on address match |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| rx_valid | output | 1 | Received byte waiting; SCL held |
| rx_ready | input | 1 | Local logic has consumed rx_data |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | tx_data is supplied |
| tx_ready | output | 1 | Target waits for a byte to send; SCL held |

## Verification
The assertions watch four things on every cycle:
- the filter never changes level without a long enough run of equal synchronized samples;
- SCL is only ever pulled while the filtered clock is low, and SDA drive changes only in the low phase;
- a waiting receive or transmit handshake keeps SCL held with its byte stable;
- an address hit is a single pulse accompanied by ACK.

Other behaviour only the bench's bus scenarios can show:
- that a five-sample clock glitch inside an address bit is ignored;
- that a wrong address is left unacknowledged along with the data that follows;
- that a repeated START restarts addressing;
- that a controller NACK stops further transmit requests;
- that long local delays appear as stretched clock low phases.

A behavioural model in the bench follows every bus edge and is compared with all outputs on each clock.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_RECV, PH_AACK, PH_RHOLD, PH_RACK,
    PH_TLOAD, PH_TSEND, PH_TACK, PH_PARK
  } phase_t;

  // Filtered line: level before this edge plus accepted-change pulses.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_t;
endpackage

// File: rtl/i2ct_glitch_filter.sv
module i2ct_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output i2ct_pkg::line_t  line_o
);
  localparam int CW      = $clog2(FILT_LEN + 1);
  localparam int RUN_MIN = FILT_LEN - 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic                   lvl_q, lvl_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   flip;

  assign smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    flip  = (smp != lvl_q) && (cnt_q == CW'(FILT_LEN - 1));
    lvl_d = flip ? smp : lvl_q;
    if ((smp == lvl_q) || flip) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o.lvl  = lvl_q;
  assign line_o.rise = flip & smp;
  assign line_o.fall = flip & ~smp;

  // Independent run-length tracker of the synchronized samples.
  logic          prev_q;
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      prev_q <= smp;
      if (smp != prev_q)                  run_q <= '0;
      else if (run_q != CW'(FILT_LEN))    run_q <= run_q + 1'b1;
    end
  end

  assert_filter_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flip |-> ((smp == prev_q) && (run_q >= CW'(RUN_MIN))));
endmodule

// File: rtl/i2ct_line_front.sv
module i2ct_line_front #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output i2ct_pkg::line_t scl_o,
  output i2ct_pkg::line_t sda_o,
  output logic            start_o,
  output logic            stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  i2ct_pkg::line_t   ln [NLINES];

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2ct_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .line_o (ln[g])
    );
  end

  assign scl_o   = ln[0];
  assign sda_o   = ln[1];
  assign start_o = ln[1].fall & ln[0].lvl;
  assign stop_o  = ln[1].rise & ln[0].lvl;
endmodule

// File: rtl/i2ct_byte_engine.sv
module i2ct_byte_engine #(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  i2ct_pkg::line_t   scl_i,
  input  i2ct_pkg::line_t   sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_ready_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_ready_o,
  output logic              addr_hit_o
);
  import i2ct_pkg::*;
  localparam int NW = $clog2(DATA_W + 1);

  phase_t            ph_q, ph_d;
  logic [NW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              adr_q, adr_d, rw_q, rw_d, nk_q, nk_d, hit_q, hit_d;

  always_comb begin
    ph_d  = ph_q;  cnt_d = cnt_q; sh_d = sh_q;
    adr_d = adr_q; rw_d  = rw_q;  nk_d = nk_q;
    hit_d = 1'b0;
    if (start_i) begin
      ph_d = PH_RECV; adr_d = 1'b1; cnt_d = '0;
    end else if (stop_i) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_RECV: begin
          if (scl_i.rise && (cnt_q != NW'(DATA_W))) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_i.lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_i.fall && (cnt_q == NW'(DATA_W))) begin
            if (!adr_q)                                  ph_d = PH_RHOLD;
            else if (sh_q[DATA_W-1 -: ADDR_W] == DEV_ADDR) begin
              ph_d = PH_AACK; rw_d = sh_q[0]; hit_d = 1'b1;
            end else                                     ph_d = PH_PARK;
          end
        end
        PH_AACK: if (scl_i.fall) begin
          adr_d = 1'b0; cnt_d = '0;
          ph_d  = rw_q ? PH_TLOAD : PH_RECV;
        end
        PH_RHOLD: if (rx_ready_i) ph_d = PH_RACK;
        PH_RACK:  if (scl_i.fall) begin ph_d = PH_RECV; cnt_d = '0; end
        PH_TLOAD: if (tx_valid_i) begin
          sh_d = tx_data_i; cnt_d = '0; ph_d = PH_TSEND;
        end
        PH_TSEND: if (scl_i.fall) begin
          sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == NW'(DATA_W - 1)) ph_d = PH_TACK;
        end
        PH_TACK: begin
          if (scl_i.rise) nk_d = sda_i.lvl;
          if (scl_i.fall) ph_d = nk_q ? PH_PARK : PH_TLOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE; cnt_q <= '0; sh_q <= '0;
      adr_q <= 1'b0;    rw_q  <= 1'b0; nk_q <= 1'b0; hit_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;  cnt_q <= cnt_d; sh_q <= sh_d;
      adr_q <= adr_d; rw_q  <= rw_d;  nk_q <= nk_d; hit_q <= hit_d;
    end
  end

  assign scl_oe_o   = (ph_q == PH_RHOLD) || (ph_q == PH_TLOAD);
  assign sda_oe_o   = (ph_q == PH_AACK) || (ph_q == PH_RHOLD) || (ph_q == PH_RACK)
                    || ((ph_q == PH_TSEND) && !sh_q[DATA_W-1]);
  assign rx_valid_o = (ph_q == PH_RHOLD);
  assign tx_ready_o = (ph_q == PH_TLOAD);
  assign rx_data_o  = sh_q;
  assign addr_hit_o = hit_q;

  assert_stretch_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> !scl_i.lvl);
  assert_sda_move_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe_o) |-> !scl_i.lvl);
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && scl_oe_o && $stable(rx_data_o)));
  assert_tx_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && !tx_valid_i) |=> (tx_ready_o && scl_oe_o));
  assert_hit_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_o |-> (sda_oe_o && !$past(addr_hit_o)));
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
  parameter int                SYNC_STAGES = 2,
  parameter int                FILT_LEN    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              addr_hit,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);
  i2ct_pkg::line_t scl_f, sda_f;
  logic            start_ev, stop_ev;

  i2ct_line_front #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_f), .sda_o(sda_f), .start_o(start_ev), .stop_o(stop_ev)
  );

  i2ct_byte_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .start_i(start_ev), .stop_i(stop_ev),
    .rx_ready_i(rx_ready), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .tx_ready_o(tx_ready), .addr_hit_o(addr_hit)
  );
endmodule

// File: tb/sim_i2c_target_stretch.sv
module sim_i2c_target_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 50;
  localparam int RX_DLY     = 300;
  localparam int TX_DLY     = 120;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_ctl = 1'b1, sda_ctl = 1'b1;
  logic scl_oe, sda_oe, addr_hit, rx_valid, tx_ready;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;
  wire scl_bus = scl_ctl & ~scl_oe;
  wire sda_bus = sda_ctl & ~sda_oe;

  int compared = 0, mismatched = 0, cyc = 0, hits = 0, tx_loads = 0;
  int rx_wait = 0, tx_wait = 0, low_run = 0, max_low = 0;
  bit done = 0;
  logic [7:0] got[$];
  logic [7:0] txq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_stretch u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_hit(addr_hit),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phases 0 idle,1 recv,2 addr-ack,3 rx hold,4 rx ack,
  // 5 tx wait,6 tx bits,7 tx ack slot,8 parked.
  int ph, nb;
  bit [7:0] sh;
  bit adr, rdm, nk, mhit, fs, fd;
  bit qc[$], qd[$];

  function automatic bit settle(bit q[$], bit cur);
    for (int i = 0; i < 6; i++) if (q[i] == cur) return cur;
    return !cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; nb = 0; sh = 0; adr = 0; rdm = 0; nk = 0; mhit = 0; fs = 1; fd = 1;
      qc.delete(); qd.delete();
      for (int i = 0; i < 8; i++) begin qc.push_back(1'b1); qd.push_back(1'b1); end
    end else begin
      bit nfs, nfd, sr, sf, dr, df;
      qc.push_back(scl_bus); void'(qc.pop_front());
      qd.push_back(sda_bus); void'(qd.pop_front());
      nfs = settle(qc, fs); nfd = settle(qd, fd);
      sr = nfs && !fs; sf = !nfs && fs; dr = nfd && !fd; df = !nfd && fd;
      mhit = 0;
      if (df && fs) begin ph = 1; adr = 1; nb = 0; end
      else if (dr && fs) ph = 0;
      else case (ph)
        1: begin
          if (sr && nb != 8) begin sh = {sh[6:0], fd}; nb++; end
          if (sf && nb == 8) begin
            if (!adr) ph = 3;
            else if (sh[7:1] == 7'h2A) begin ph = 2; rdm = sh[0]; mhit = 1; end
            else ph = 8;
          end
        end
        2: if (sf) begin adr = 0; nb = 0; ph = rdm ? 5 : 1; end
        3: if (rx_ready) ph = 4;
        4: if (sf) begin ph = 1; nb = 0; end
        5: if (tx_valid) begin sh = tx_data; nb = 0; ph = 6; end
        6: if (sf) begin sh = {sh[6:0], 1'b0}; if (nb == 7) ph = 7; nb++; end
        7: begin if (sr) nk = fd; if (sf) ph = nk ? 8 : 5; end
        default: ;
      endcase
      fs = nfs; fd = nfd;
    end
  end

  // Per-cycle comparison against the model, plus local-side responder.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(scl_oe === (ph == 3 || ph == 5), "R7", "scl_oe vs model", scl_oe, (ph == 3 || ph == 5));
      chk(sda_oe === (ph == 2 || ph == 3 || ph == 4 || (ph == 6 && !sh[7])), "R5",
          "sda_oe vs model", sda_oe, (ph == 2 || ph == 3 || ph == 4 || (ph == 6 && !sh[7])));
      chk(rx_valid === (ph == 3), "R4", "rx_valid vs model", rx_valid, (ph == 3));
      chk(tx_ready === (ph == 5), "R6", "tx_ready vs model", tx_ready, (ph == 5));
      chk(addr_hit === mhit, "R3", "addr_hit vs model", addr_hit, mhit);
      if (ph == 3) chk(rx_data === sh, "R4", "rx_data vs model", rx_data, sh);
      if (addr_hit) hits++;
      if (scl_ctl && !scl_bus) begin low_run++; if (low_run > max_low) max_low = low_run; end
      else low_run = 0;
      if (rx_valid && !rx_ready) begin
        rx_wait++;
        if (rx_wait >= RX_DLY) begin rx_ready = 1'b1; got.push_back(rx_data); rx_wait = 0; end
      end else rx_ready = 1'b0;
      if (tx_ready && !tx_valid) begin
        tx_wait++;
        if (tx_wait >= TX_DLY) begin
          tx_valid = 1'b1; tx_data = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
          tx_loads++; tx_wait = 0;
        end
      end else tx_valid = 1'b0;
    end
    if (cyc == WD_LIMIT && !done) begin
      compared++; mismatched++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl_high(); while (scl_bus !== 1'b1) @(negedge clk); endtask

  task automatic clk_bit(input bit b, input bit glitch, output bit seen);
    sda_ctl = b; wait_cyc(H/2);
    scl_ctl = 1'b1; wait_scl_high();
    if (glitch) begin
      wait_cyc(10); scl_ctl = 1'b0; wait_cyc(5); scl_ctl = 1'b1; wait_cyc(H/2 - 15);
    end else wait_cyc(H/2);
    seen = sda_bus; wait_cyc(H/2);
    scl_ctl = 1'b0; wait_cyc(H/2);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; wait_cyc(H/2);
    scl_ctl = 1'b1; wait_scl_high(); wait_cyc(H/2);
    sda_ctl = 1'b0; wait_cyc(H/2);
    scl_ctl = 1'b0; wait_cyc(H/2);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; wait_cyc(H/2);
    scl_ctl = 1'b1; wait_scl_high(); wait_cyc(H/2);
    sda_ctl = 1'b1; wait_cyc(H);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit glitch_first, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch_first && i == 7, s);
    clk_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 1'b0, s); d[i] = s; end
    clk_bit(nack, 1'b0, s);
  endtask

  initial begin
    bit ack;
    logic [7:0] rd;
    int h0, l0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk({scl_oe, sda_oe, rx_valid, tx_ready, addr_hit} === 5'b0, "R2", "idle outputs after reset",
        {scl_oe, sda_oe, rx_valid, tx_ready, addr_hit}, 0);

    // R1: five-sample SDA dip while idle must not start a transfer.
    sda_ctl = 1'b0; wait_cyc(5); sda_ctl = 1'b1; wait_cyc(40);
    chk(hits == 0 && sda_oe == 1'b0, "R1", "short SDA dip ignored", hits, 0);

    // R1/R3/R4/R8: write with a clock glitch inside the first address bit.
    bus_start();
    write_byte(8'h54, 1'b1, ack);
    chk(ack, "R1", "address ACK despite SCL glitch", ack, 1);
    chk(hits == 1, "R3", "addr_hit pulses on match", hits, 1);
    max_low = 0;
    write_byte(8'hA5, 1'b0, ack); chk(ack, "R4", "ACK data byte 1", ack, 1);
    write_byte(8'h3C, 1'b0, ack); chk(ack, "R4", "ACK data byte 2", ack, 1);
    chk(max_low >= RX_DLY - 50, "R8", "receive stretch length", max_low, RX_DLY - 50);
    bus_stop();
    chk(got.size() == 2 && got[0] == 8'hA5 && got[1] == 8'h3C, "R4", "received bytes",
        {got.size() > 0 ? got[0] : 8'h0, got.size() > 1 ? got[1] : 8'h0}, 16'hA53C);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R2", "STOP releases lines", {scl_oe, sda_oe}, 0);

    // R3: wrong address, then a data byte, both left unacknowledged.
    h0 = hits; l0 = got.size();
    bus_start();
    write_byte(8'h44, 1'b0, ack); chk(!ack, "R3", "no ACK on mismatch", ack, 0);
    write_byte(8'h11, 1'b0, ack); chk(!ack, "R3", "data ignored after mismatch", ack, 0);
    bus_stop();
    chk(hits == h0 && got.size() == l0, "R3", "no hit or byte on mismatch", hits - h0, 0);

    // R5/R6: read two bytes, NACK the second, then clock one more byte.
    txq.push_back(8'h96); txq.push_back(8'h5A);
    bus_start();
    max_low = 0;
    write_byte(8'h55, 1'b0, ack); chk(ack, "R3", "read address ACK", ack, 1);
    read_byte(1'b0, rd); chk(rd == 8'h96, "R5", "first sent byte", rd, 8'h96);
    chk(max_low >= TX_DLY - 50, "R5", "transmit stretch length", max_low, TX_DLY - 50);
    read_byte(1'b1, rd); chk(rd == 8'h5A, "R5", "second sent byte", rd, 8'h5A);
    read_byte(1'b1, rd); chk(rd == 8'hFF, "R6", "SDA released after NACK", rd, 8'hFF);
    chk(tx_loads == 2, "R6", "no transmit request after NACK", tx_loads, 2);
    bus_stop();

    // R2: repeated START in the middle of a write restarts addressing.
    h0 = hits;
    bus_start();
    write_byte(8'h54, 1'b0, ack);
    write_byte(8'h77, 1'b0, ack); chk(ack, "R4", "ACK before repeated start", ack, 1);
    bus_start();
    write_byte(8'h54, 1'b0, ack); chk(ack, "R2", "address ACK after repeated START", ack, 1);
    write_byte(8'h0F, 1'b0, ack);
    bus_stop();
    chk(hits == h0 + 2, "R2", "two hits across repeated START", hits - h0, 2);
    chk(got.size() == 4 && got[2] == 8'h77 && got[3] == 8'h0F, "R2", "bytes across repeated START",
        got.size(), 4);

    wait_cyc(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule